// File: doc/BRIEF.md
# Probabilistic Batch Arbiter for a Staged Memory Scheduler

This block sits between per-source batch queues and the per-bank DRAM queues of a memory controller. Each source (a CPU core or a graphics engine) presents the head of its oldest complete batch. Every batch is a run of requests to the same DRAM row. The arbiter picks one source, streams that batch out request by request, and then makes its next choice.

Each choice uses one of two policies. The first is shortest-job-first, which favours the source with the fewest requests still in flight. The second is a rotating order, which lets heavy sources make progress. An 8-bit LFSR is compared against a software-written threshold to pick the policy at each decision. A low threshold favours bandwidth-hungry sources. A high threshold favours latency-sensitive ones. The block keeps a per-source in-flight count. Each issued request raises the count, and each completion indication lowers it.

Top module: `prob_batch_arbiter`

## Requirements
- R1: While reset is held, and until the first decision after release, `grant_valid`, `issue_valid` and every `src_pop` bit are 0, and the rotation pointer starts at source 0.
- R2: A decision is made only among sources whose `batch_rdy` bit is 1. When no source is ready there is no grant and no request is issued.
- R3: When `grant_sjf` is 1, the granted source is the ready source with the smallest in-flight count. Among equal counts, the first one found scanning upward (with wrap) from the rotation pointer wins.
- R4: When `grant_sjf` is 0, the granted source is the first ready source found scanning upward (with wrap) from the rotation pointer.
- R5: After every grant in either policy, the rotation pointer moves to the source following the granted one, wrapping from N_SRC-1 to 0.
- R6: The policy is shortest-job-first when the LFSR value (never zero, 1..255) is at or below `prob_thresh`, and rotating otherwise. The LFSR steps once per decision. A threshold of 0 never selects shortest-job-first, and a threshold of 255 always does.
- R7: Over a long run, the fraction of shortest-job-first decisions is close to `prob_thresh`/255. Examples are about 90% at 230 and about 50% at 128.
- R8: A granted batch is issued one request per cycle, in source order, with exactly one `src_pop` bit set for the granted source. No other grant occurs until the request flagged by `head_last` has been issued. The cycle after that request has no issue.
- R9: A source's in-flight count rises by one for each of its issued requests and falls by one for each `cpl_valid` naming it. Both events in the same cycle leave the count unchanged.
- R10: A decision is made in the cycle in which the arbiter is idle and some source is ready. `grant_valid` pulses for one cycle in the next cycle, together with the first issued request of that batch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prob_thresh | input | PROB_W | Threshold for the shortest-job-first policy |
| batch_rdy | input | N_SRC | Source has a complete batch at its head |
| head_data | input | N_SRC*DATA_W | Head request of each source, source i in slice i |
| head_last | input | N_SRC | Head request is the final one of its batch |
| cpl_valid | input | 1 | A request has completed |
| cpl_src | input | IDX_W | Source of the completed request |
| src_pop | output | N_SRC | Consume the head request of a source |
| issue_valid | output | 1 | A request is forwarded this cycle |
| issue_src | output | IDX_W | Source of the forwarded request |
| issue_data | output | DATA_W | Forwarded request |
| grant_valid | output | 1 | One-cycle pulse that starts a new batch |
| grant_src | output | IDX_W | Source granted |
| grant_sjf | output | 1 | Policy used for the current grant (1 = shortest-job-first) |

## Verification
The assertions check the following on every cycle:
- at most one pop at a time;
- a grant only to a source that was ready at the decision;
- the grant pulse coinciding with the first issued request;
- an unchanged source until the final request of a batch, followed by an idle cycle;
- the forced policy at threshold 0 and 255.

Only the bench's scenarios can show which source wins. That requires a model of in-flight counts, pointer rotation and tie order across random arrivals and completions. The bench also measures the policy mix at intermediate thresholds over hundreds of decisions and follows request order within each batch.

// File: rtl/pba_pkg.sv
package pba_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_FWD = 1'b1} arb_state_e;
endpackage

// File: rtl/pba_lfsr.sv
// Galois LFSR that steps only when a decision consumes a random value.
module pba_lfsr #(
  parameter int             W    = 8,
  parameter logic [W-1:0]   TAPS = 8'hB8,
  parameter logic [W-1:0]   SEED = 8'h5A
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] value
);
  logic [W-1:0] lfsr_q, lfsr_d;

  always_comb begin
    if (lfsr_q[0]) lfsr_d = (lfsr_q >> 1) ^ TAPS;
    else           lfsr_d = lfsr_q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lfsr_q <= SEED;
    else if (step) lfsr_q <= lfsr_d;
  end

  assign value = lfsr_q;
endmodule

// File: rtl/pba_outstanding.sv
// One in-flight counter per source: up on issue, down on completion.
module pba_outstanding #(
  parameter int N_SRC = 4,
  parameter int CNT_W = 6,
  parameter int IDX_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inc_vld,
  input  logic [IDX_W-1:0]       inc_src,
  input  logic                   dec_vld,
  input  logic [IDX_W-1:0]       dec_src,
  output logic [N_SRC*CNT_W-1:0] cnt_flat
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             up, dn;

    assign up = inc_vld && (inc_src == IDX_W'(g));
    assign dn = dec_vld && (dec_src == IDX_W'(g));

    always_comb begin
      cnt_d = cnt_q;
      if (up && !dn)      cnt_d = cnt_q + 1'b1;
      else if (dn && !up) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (up != dn) cnt_q <= cnt_d;
    end

    assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q;
  end
endmodule

// File: rtl/pba_pick.sv
// Scans sources from the rotation pointer; the first ready one wins unless
// shortest-job-first mode finds a strictly smaller in-flight count later.
module pba_pick #(
  parameter int N_SRC = 4,
  parameter int CNT_W = 6,
  parameter int IDX_W = 2
) (
  input  logic [N_SRC-1:0]       rdy,
  input  logic [N_SRC*CNT_W-1:0] cnt_flat,
  input  logic [IDX_W-1:0]       ptr,
  input  logic                   use_sjf,
  output logic                   any,
  output logic [IDX_W-1:0]       sel
);
  logic             found;
  logic [IDX_W-1:0] idx, best;
  logic [CNT_W-1:0] best_cnt, cur_cnt;
  int               pos;

  always_comb begin
    found    = 1'b0;
    best     = ptr;
    best_cnt = '1;
    idx      = '0;
    cur_cnt  = '0;
    pos      = 0;
    for (int k = 0; k < N_SRC; k++) begin
      pos = int'(ptr) + k;
      if (pos >= N_SRC) pos = pos - N_SRC;
      idx     = IDX_W'(pos);
      cur_cnt = cnt_flat[idx*CNT_W +: CNT_W];
      if (rdy[idx]) begin
        if (!found) begin
          found    = 1'b1;
          best     = idx;
          best_cnt = cur_cnt;
        end else if (use_sjf && (cur_cnt < best_cnt)) begin
          best     = idx;
          best_cnt = cur_cnt;
        end
      end
    end
    any = found;
    sel = best;
  end
endmodule

// File: rtl/prob_batch_arbiter.sv
module prob_batch_arbiter
  import pba_pkg::*;
#(
  parameter int                N_SRC     = 4,
  parameter int                DATA_W    = 16,
  parameter int                CNT_W     = 6,
  parameter int                PROB_W    = 8,
  parameter logic [PROB_W-1:0] LFSR_TAPS = 8'hB8,
  parameter logic [PROB_W-1:0] LFSR_SEED = 8'h5A,
  localparam int               IDX_W     = $clog2(N_SRC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PROB_W-1:0]       prob_thresh,
  input  logic [N_SRC-1:0]        batch_rdy,
  input  logic [N_SRC*DATA_W-1:0] head_data,
  input  logic [N_SRC-1:0]        head_last,
  input  logic                    cpl_valid,
  input  logic [IDX_W-1:0]        cpl_src,
  output logic [N_SRC-1:0]        src_pop,
  output logic                    issue_valid,
  output logic [IDX_W-1:0]        issue_src,
  output logic [DATA_W-1:0]       issue_data,
  output logic                    grant_valid,
  output logic [IDX_W-1:0]        grant_src,
  output logic                    grant_sjf
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SRC - 1);
  localparam logic [N_SRC-1:0] ONE_HOT0 = {{(N_SRC-1){1'b0}}, 1'b1};

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  arb_state_e                 state_q, state_d;
  logic [IDX_W-1:0]           cur_q, cur_d, ptr_q, ptr_d;
  logic                       gv_q, gv_d, gs_q, gs_d;
  logic [PROB_W-1:0]          lfsr_val;
  logic [N_SRC*CNT_W-1:0]     cnt_flat;
  logic                       any_rdy, use_sjf, decide;
  logic [IDX_W-1:0]           pick;

  assign use_sjf = (lfsr_val <= prob_thresh);
  assign decide  = (state_q == ST_IDLE) && any_rdy;

  pba_lfsr #(
    .W    (PROB_W),
    .TAPS (LFSR_TAPS),
    .SEED (LFSR_SEED)
  ) i_lfsr (
    .clk   (clk),
    .rst_n (rst_n_int),
    .step  (decide),
    .value (lfsr_val)
  );

  pba_pick #(
    .N_SRC (N_SRC),
    .CNT_W (CNT_W),
    .IDX_W (IDX_W)
  ) i_pick (
    .rdy      (batch_rdy),
    .cnt_flat (cnt_flat),
    .ptr      (ptr_q),
    .use_sjf  (use_sjf),
    .any      (any_rdy),
    .sel      (pick)
  );

  pba_outstanding #(
    .N_SRC (N_SRC),
    .CNT_W (CNT_W),
    .IDX_W (IDX_W)
  ) i_outstanding (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .inc_vld  (issue_valid),
    .inc_src  (cur_q),
    .dec_vld  (cpl_valid),
    .dec_src  (cpl_src),
    .cnt_flat (cnt_flat)
  );

  // next state
  always_comb begin
    state_d = state_q;
    cur_d   = pick;
    ptr_d   = (pick == LAST_IDX) ? '0 : pick + 1'b1;
    gs_d    = use_sjf;
    gv_d    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (any_rdy) begin
          state_d = ST_FWD;
          gv_d    = 1'b1;
        end
      end
      ST_FWD: begin
        if (head_last[cur_q]) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= ST_IDLE;
      gv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      gv_q    <= gv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      cur_q <= '0;
      ptr_q <= '0;
      gs_q  <= 1'b0;
    end else if (decide) begin
      cur_q <= cur_d;
      ptr_q <= ptr_d;
      gs_q  <= gs_d;
    end
  end

  // outputs
  assign issue_valid = (state_q == ST_FWD);
  assign issue_src   = cur_q;
  assign issue_data  = head_data[cur_q*DATA_W +: DATA_W];
  assign src_pop     = issue_valid ? (ONE_HOT0 << cur_q) : '0;
  assign grant_valid = gv_q;
  assign grant_src   = cur_q;
  assign grant_sjf   = gs_q;
endmodule

// File: rtl/prob_batch_arbiter_chk.sv
module prob_batch_arbiter_chk #(
  parameter int N_SRC  = 4,
  parameter int PROB_W = 8,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PROB_W-1:0] prob_thresh,
  input logic [N_SRC-1:0]  batch_rdy,
  input logic [N_SRC-1:0]  head_last,
  input logic [N_SRC-1:0]  src_pop,
  input logic              issue_valid,
  input logic [IDX_W-1:0]  issue_src,
  input logic              grant_valid,
  input logic [IDX_W-1:0]  grant_src,
  input logic              grant_sjf
);
  localparam logic [N_SRC-1:0] ONE_HOT0 = {{(N_SRC-1){1'b0}}, 1'b1};

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!issue_valid && !grant_valid && (src_pop == '0));
    end
  end

  a_r8_one_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_pop));

  a_r2_grant_was_ready: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (($past(batch_rdy) & (ONE_HOT0 << grant_src)) != '0));

  a_r10_grant_with_issue: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (issue_valid && (issue_src == grant_src)));

  a_r8_hold_source: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !head_last[issue_src]) |=>
      (issue_valid && !grant_valid && (issue_src == $past(issue_src))));

  a_r8_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && head_last[issue_src]) |=> !issue_valid);

  a_r6_zero_thresh: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && ($past(prob_thresh) == '0)) |-> !grant_sjf);

  a_r6_full_thresh: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && ($past(prob_thresh) == '1)) |-> grant_sjf);
endmodule

bind prob_batch_arbiter prob_batch_arbiter_chk #(
  .N_SRC  (N_SRC),
  .PROB_W (PROB_W),
  .IDX_W  (IDX_W)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prob_thresh (prob_thresh),
  .batch_rdy   (batch_rdy),
  .head_last   (head_last),
  .src_pop     (src_pop),
  .issue_valid (issue_valid),
  .issue_src   (issue_src),
  .grant_valid (grant_valid),
  .grant_src   (grant_src),
  .grant_sjf   (grant_sjf)
);

// File: tb/test_prob_batch_arbiter.sv
`timescale 1ns/1ps
module test_prob_batch_arbiter;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam int CW = 6;
  localparam int PW = 8;
  localparam int IW = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [PW-1:0]   prob_thresh;
  logic [N-1:0]    batch_rdy;
  logic [N*DW-1:0] head_data;
  logic [N-1:0]    head_last;
  logic            cpl_valid;
  logic [IW-1:0]   cpl_src;
  logic [N-1:0]    src_pop;
  logic            issue_valid;
  logic [IW-1:0]   issue_src;
  logic [DW-1:0]   issue_data;
  logic            grant_valid;
  logic [IW-1:0]   grant_src;
  logic            grant_sjf;

  always #10 clk = ~clk;

  prob_batch_arbiter #(.N_SRC(N), .DATA_W(DW), .CNT_W(CW), .PROB_W(PW)) i_prob_batch_arbiter (
    .clk(clk), .rst_n(rst_n), .prob_thresh(prob_thresh), .batch_rdy(batch_rdy),
    .head_data(head_data), .head_last(head_last), .cpl_valid(cpl_valid), .cpl_src(cpl_src),
    .src_pop(src_pop), .issue_valid(issue_valid), .issue_src(issue_src),
    .issue_data(issue_data), .grant_valid(grant_valid), .grant_src(grant_src),
    .grant_sjf(grant_sjf)
  );

  int n_checks = 0;
  int n_errors = 0;

  // bench model of sources and arbiter expectations
  int pend[N];
  int rem[N];
  int seq[N];
  int cnt[N];
  int ptr, cur, exp_rr, exp_sjf, dec_thresh;
  bit busy, pending_dec;
  int add_pct, cpl_pct;
  int n_grants, n_sjf;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [DW-1:0] exp_data(input int s);
    return DW'(s * 4096 + (seq[s] % 4096));
  endfunction

  function automatic bit any_pend();
    for (int i = 0; i < N; i++) if (pend[i] > 0) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int pick_rr();
    for (int k = 0; k < N; k++) begin
      int s = (ptr + k) % N;
      if (pend[s] > 0) return s;
    end
    return -1;
  endfunction

  function automatic int pick_sjf();
    int best = -1;
    for (int k = 0; k < N; k++) begin
      int s = (ptr + k) % N;
      if (pend[s] > 0 && (best < 0 || cnt[s] < cnt[best])) best = s;
    end
    return best;
  endfunction

  task automatic drive_inputs();
    for (int i = 0; i < N; i++) begin
      batch_rdy[i]            = (pend[i] > 0);
      head_last[i]            = (rem[i] == 1);
      head_data[i*DW +: DW]   = exp_data(i);
    end
  endtask

  task automatic step_cycle();
    int  exp_src;
    int  s;
    bit  gs, cv;
    @(negedge clk);
    if (pending_dec) begin
      gs      = grant_sjf;
      exp_src = gs ? exp_sjf : exp_rr;
      chk(grant_valid === 1'b1, "R10", int'(grant_valid), 1);
      if (gs) chk(int'(grant_src) == exp_src, "R3 R5 R9", int'(grant_src), exp_src);
      else    chk(int'(grant_src) == exp_src, "R4 R5", int'(grant_src), exp_src);
      if (dec_thresh == 0)   chk(!gs, "R6", int'(gs), 0);
      if (dec_thresh == 255) chk(gs, "R6", int'(gs), 1);
      n_grants++;
      if (gs) n_sjf++;
      busy        = 1'b1;
      cur         = exp_src;
      ptr         = (exp_src + 1) % N;
      pending_dec = 1'b0;
    end else begin
      chk(grant_valid === 1'b0, busy ? "R8" : "R2", int'(grant_valid), 0);
    end
    if (busy) begin
      chk(issue_valid === 1'b1, "R8", int'(issue_valid), 1);
      chk(int'(issue_src) == cur, "R8", int'(issue_src), cur);
      chk(issue_data == exp_data(cur), "R8", int'(issue_data), int'(exp_data(cur)));
      chk(int'(src_pop) == (1 << cur), "R8", int'(src_pop), 1 << cur);
    end else begin
      chk(issue_valid === 1'b0 && src_pop == '0, "R2", int'(src_pop), 0);
    end
    if (!busy && any_pend()) begin
      pending_dec = 1'b1;
      exp_rr      = pick_rr();
      exp_sjf     = pick_sjf();
      dec_thresh  = int'(prob_thresh);
    end
    cv = 1'b0;
    s  = int'($urandom_range(N - 1));
    if (int'($urandom_range(99)) < cpl_pct && cnt[s] > 0) cv = 1'b1;
    cpl_valid = cv;
    cpl_src   = IW'(s);
    if (busy) cnt[cur]++;
    if (cv)   cnt[s]--;
    @(posedge clk);
    #1;
    if (busy) begin
      seq[cur]++;
      rem[cur]--;
      if (rem[cur] == 0) begin
        pend[cur]--;
        busy = 1'b0;
      end
    end
    for (int i = 0; i < N; i++) begin
      if (int'($urandom_range(99)) < add_pct && pend[i] < 6 && cnt[i] < 40) pend[i]++;
      if (pend[i] > 0 && rem[i] == 0) rem[i] = int'($urandom_range(1, 4));
    end
    drive_inputs();
  endtask

  task automatic run_phase(input int thresh, input int cycles, input int addp, input int cplp);
    prob_thresh = PW'(thresh);
    add_pct     = addp;
    cpl_pct     = cplp;
    n_grants    = 0;
    n_sjf       = 0;
    for (int c = 0; c < cycles; c++) step_cycle();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; prob_thresh = '0; batch_rdy = '0; head_data = '0;
    head_last = '0; cpl_valid = 1'b0; cpl_src = '0;
    for (int i = 0; i < N; i++) begin pend[i] = 0; rem[i] = 0; seq[i] = 0; cnt[i] = 0; end
    ptr = 0; cur = 0; busy = 1'b0; pending_dec = 1'b0; dec_thresh = 0;
    add_pct = 0; cpl_pct = 0;
    repeat (3) @(negedge clk);
    // R1: quiet while reset is held
    chk(grant_valid === 1'b0 && issue_valid === 1'b0 && src_pop == '0, "R1", int'(issue_valid), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    // R1/R2: idle after release with no batch ready
    run_phase(255, 5, 0, 0);

    // directed: all sources ready at once, equal counts, SJF forced (tie from pointer 0)
    prob_thresh = 8'hFF;
    for (int i = 0; i < N; i++) begin pend[i] = 1; rem[i] = 2; end
    drive_inputs();
    run_phase(255, 20, 0, 0);
    chk(pend[0] == 0 && pend[3] == 0, "R3", pend[3], 0);

    run_phase(0, 600, 30, 70);     // pure rotation
    run_phase(255, 600, 30, 70);   // pure shortest-job-first
    run_phase(230, 1500, 30, 70);  // mostly shortest-job-first
    chk(n_grants > 0 && n_sjf * 100 >= n_grants * 80 && n_sjf * 100 <= n_grants * 97,
        "R7", (n_grants > 0) ? n_sjf * 100 / n_grants : 0, 90);
    run_phase(128, 1200, 30, 70);  // even mix
    chk(n_grants > 0 && n_sjf * 100 >= n_grants * 35 && n_sjf * 100 <= n_grants * 65,
        "R7", (n_grants > 0) ? n_sjf * 100 / n_grants : 0, 50);
    run_phase(128, 150, 0, 70);    // drain, then idle: R2
    chk(!any_pend() && issue_valid === 1'b0, "R2", int'(issue_valid), 0);
    finish_run();
  end
endmodule